// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller sits beside a small processor core and decides, one instruction boundary at a time, whether an interrupt is taken and at which vector address the core must continue. It takes two kinds of sources. Latched sources capture a one-cycle event pulse into a sticky flag. Level sources request service only while their input line is high. Each source has its own enable. A global enable masks all sources at once.

When a source wins, the block raises a take request and holds it until the core acknowledges it. Together with the request it holds a vector address, formed from a selectable base plus the source index times two. Taking an interrupt drops the global enable. The core re-arms it with a return or with an explicit set command, and the explicit set allows nested handlers. A disable command wins over everything in its own cycle. After a return, one more main-program instruction always completes before any pending source is taken. A separate configuration input relocates the reset vector to the boot region.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While rst_ni is low, take_o and gie_o are 0. rst_vec_o is 0 when rst_vec_boot_i is 0, and BOOT_BASE (default 12'hC00) when it is 1.
- R2: Index 0 is reserved for reset and never requests. Among pending sources, the lowest index wins. The address is base + 2*index, so index 2 gives 4, index 3 gives 6 and index 5 gives 10.
- R3: A source is pending only when its src_en_i bit is 1. A take is decided only in a cycle with retire_i=1 and gie_o=1. take_o rises on the following clock edge.
- R4: On a take, gie_o becomes 0 in the same edge that raises take_o. reti_i sets gie_o on the next edge. gie_set_i sets it on the next edge even inside a handler, which permits nesting.
- R5: Sources 1 to 3 (FLAG_MASK default 8'b0000_1110) are latched. A pulse on src_i sets the flag even while the source or the global enable is off. The flag is served later, once both enables are on. Taking that source clears its flag.
- R6: When flag_clr_we_i=1, each one in flag_clr_data_i clears the matching flag. An event arriving in the same cycle as its clear leaves the flag set.
- R7: Sources 4 to 7 are level sources with no memory. A condition that drops before its enable turns on causes no take.
- R8: After reti_i, the first retire_i never takes an interrupt. The earliest take is decided at the second retire_i.
- R9: gie_clr_i clears gie_o on the next edge. It also blocks a take decision in its own cycle, even when a source and a retire are present in that cycle.
- R10: With vec_sel_boot_i=1, the vector base is BOOT_BASE. For example, index 2 gives 12'hC04.
- R11: Once raised, take_o and vec_addr_o hold until take_ack_i. The ack clears take_o on the next edge. No new decision is made while take_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Event pulses for latched sources, condition lines for level sources |
| src_en_i | input | N_SRC | Per-source enables |
| retire_i | input | 1 | An instruction completed; this cycle is a decision boundary |
| reti_i | input | 1 | Return from interrupt executed |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable, effective at once |
| flag_clr_we_i | input | 1 | Write strobe for clearing flags |
| flag_clr_data_i | input | N_SRC | Write-one-to-clear flag mask |
| vec_sel_boot_i | input | 1 | Vector base at the boot region |
| rst_vec_boot_i | input | 1 | Reset vector at the boot region |
| take_ack_i | input | 1 | Core acknowledges the take request |
| take_o | output | 1 | Interrupt take request |
| vec_addr_o | output | AW | Vector address of the taken source |
| gie_o | output | 1 | Global enable state |
| rst_vec_o | output | AW | Reset vector address |

## Verification
A flag that is wrongly kept or lost only shows at the ports at a later retire boundary. The bench therefore re-enables the source and retires, and expects take_o exactly one edge after that boundary, or expects no take at all. A wrong global-enable or post-return state shows on gie_o, or as take_o rising one edge too early or too late. For this reason every step states the exact values of take_o and gie_o after each edge. A latched vector that drifts shows as vec_addr_o changing while take_o is held. The bench provokes this by changing the base select mid-request.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int unsigned N_SRC_DEF = 8;
  localparam int unsigned AW_DEF    = 12;
  localparam int unsigned STRIDE    = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned N         = 8,
  parameter logic [N-1:0] FLAG_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] pend_o
);
  assign pend_o[0] = 1'b0;  // slot 0 is reset

  for (genvar i = 1; i < N; i++) begin : g_src
    if (FLAG_MASK[i]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= (flag_q & ~sw_clr_i[i] & ~hw_clr_i[i]) | src_i[i];
      end
      assign pend_o[i] = flag_q & en_i[i];
    end else begin : g_level
      assign pend_o[i] = src_i[i] & en_i[i];
    end
  end
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate #(
  parameter int unsigned    IW        = 3,
  parameter int unsigned    AW        = 12,
  parameter logic [AW-1:0]  BOOT_BASE = '0,
  parameter int unsigned    STRIDE    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          retire_i,
  input  logic          reti_i,
  input  logic          gie_set_i,
  input  logic          gie_clr_i,
  input  logic          take_ack_i,
  input  logic          vec_sel_boot_i,
  input  logic          pend_any_i,
  input  logic [IW-1:0] pend_idx_i,
  output logic          decide_o,
  output logic          take_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          gie_o
);
  localparam logic [AW-1:0] STRIDE_W = AW'(STRIDE);

  logic          gie_q, block_q, take_q;
  logic [AW-1:0] vec_q, vec_d;

  // block_q: a return happened, and no instruction has completed since
  assign decide_o = retire_i & ~reti_i & ~block_q & ~take_q &
                    gie_q & ~gie_clr_i & pend_any_i;

  assign vec_d = (vec_sel_boot_i ? BOOT_BASE : '0) + AW'(pend_idx_i) * STRIDE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      block_q <= 1'b0;
      take_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (gie_clr_i || decide_o)   gie_q <= 1'b0;
      else if (reti_i || gie_set_i) gie_q <= 1'b1;

      if (reti_i)        block_q <= 1'b1;
      else if (retire_i) block_q <= 1'b0;

      if (decide_o) begin
        take_q <= 1'b1;
        vec_q  <= vec_d;
      end else if (take_ack_i) begin
        take_q <= 1'b0;
      end
    end
  end

  assign take_o     = take_q;
  assign vec_addr_o = vec_q;
  assign gie_o      = gie_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned        N_SRC     = N_SRC_DEF,
  parameter int unsigned        AW        = AW_DEF,
  parameter logic [AW-1:0]      BOOT_BASE = 12'hC00,
  parameter logic [N_SRC-1:0]   FLAG_MASK = 8'b0000_1110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             retire_i,
  input  logic             reti_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             flag_clr_we_i,
  input  logic [N_SRC-1:0] flag_clr_data_i,
  input  logic             vec_sel_boot_i,
  input  logic             rst_vec_boot_i,
  input  logic             take_ack_i,
  output logic             take_o,
  output logic [AW-1:0]    vec_addr_o,
  output logic             gie_o,
  output logic [AW-1:0]    rst_vec_o
);
  localparam int unsigned IW = idx_w(N_SRC);

  logic [N_SRC-1:0] pend, sw_clr, hw_clr;
  logic             pend_any, decide;
  logic [IW-1:0]    pend_idx;

  assign sw_clr    = flag_clr_we_i ? flag_clr_data_i : '0;
  assign hw_clr    = decide ? (N_SRC'(1) << pend_idx) : '0;
  assign rst_vec_o = rst_vec_boot_i ? BOOT_BASE : '0;

  irq_flag_bank #(.N(N_SRC), .FLAG_MASK(FLAG_MASK)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .en_i     (src_en_i),
    .sw_clr_i (sw_clr),
    .hw_clr_i (hw_clr),
    .pend_o   (pend)
  );

  irq_prio #(.N(N_SRC), .IW(IW)) u_prio (
    .req_i (pend),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  irq_gate #(.IW(IW), .AW(AW), .BOOT_BASE(BOOT_BASE), .STRIDE(STRIDE)) u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_i       (retire_i),
    .reti_i         (reti_i),
    .gie_set_i      (gie_set_i),
    .gie_clr_i      (gie_clr_i),
    .take_ack_i     (take_ack_i),
    .vec_sel_boot_i (vec_sel_boot_i),
    .pend_any_i     (pend_any),
    .pend_idx_i     (pend_idx),
    .decide_o       (decide),
    .take_o         (take_o),
    .vec_addr_o     (vec_addr_o),
    .gie_o          (gie_o)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vec_ctrl_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retire_i,
  input logic          reti_i,
  input logic          gie_clr_i,
  input logic          take_ack_i,
  input logic          take_o,
  input logic [AW-1:0] vec_addr_o,
  input logic          gie_o
);
  assert_even_vector_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o[0] == 1'b0));

  assert_retire_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && !retire_i) |=> !take_o);

  assert_take_drops_gie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) |-> !gie_o);

  assert_no_take_on_reti_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o) |=> !take_o);

  assert_clr_blocks_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_clr_i && !take_o) |=> !take_o);

  assert_clr_drops_gie_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |=> !gie_o);

  assert_hold_until_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_ack_i) |=> (take_o && $stable(vec_addr_o)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .retire_i   (retire_i),
  .reti_i     (reti_i),
  .gie_clr_i  (gie_clr_i),
  .take_ack_i (take_ack_i),
  .take_o     (take_o),
  .vec_addr_o (vec_addr_o),
  .gie_o      (gie_o)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] BOOT = 12'hC00;
  localparam logic [N-1:0]  FMASK = 8'b0000_1110;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] src = '0, en = '0, clr_data = '0;
  logic retire = 0, reti = 0, gset = 0, gclr = 0, clr_we = 0, ivsel = 0, rboot = 0, ack = 0;
  logic take;
  logic [AW-1:0] vec, rvec;
  logic gie;

  int checks = 0, fails = 0;
  bit done = 0;

  bit            q_take[$];
  logic [AW-1:0] q_vec[$];
  bit            q_gie[$];
  string         q_tag[$];

  always #10 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .src_i (src), .src_en_i (en),
    .retire_i (retire), .reti_i (reti), .gie_set_i (gset), .gie_clr_i (gclr),
    .flag_clr_we_i (clr_we), .flag_clr_data_i (clr_data),
    .vec_sel_boot_i (ivsel), .rst_vec_boot_i (rboot), .take_ack_i (ack),
    .take_o (take), .vec_addr_o (vec), .gie_o (gie), .rst_vec_o (rvec)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: push expectation for the coming edge, then clear pulses
  task automatic step(input bit t, input logic [AW-1:0] v, input bit g, input string tag);
    q_take.push_back(t); q_vec.push_back(v); q_gie.push_back(g); q_tag.push_back(tag);
    @(negedge clk);
    retire = 0; reti = 0; gset = 0; gclr = 0; clr_we = 0; ack = 0;
    src = src & ~FMASK;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_take.size() > 0) begin
        bit t, g; logic [AW-1:0] v; string tag;
        t = q_take.pop_front(); v = q_vec.pop_front(); g = q_gie.pop_front(); tag = q_tag.pop_front();
        chk(take == t, {tag, " take_o"}, AW'(take), AW'(t));
        chk(gie == g, {tag, " gie_o"}, AW'(gie), AW'(g));
        if (t) chk(vec == v, {tag, " vec_addr_o"}, vec, v);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(take == 1'b0, "R1 reset take_o", AW'(take), '0);
    chk(gie == 1'b0, "R1 reset gie_o", AW'(gie), '0);
    chk(rvec == '0, "R1 reset vector default", rvec, '0);
    rboot = 1; #1;
    chk(rvec == BOOT, "R10 reset vector boot", rvec, BOOT);
    rboot = 0;
    @(negedge clk); rst_ni = 1;

    // R5 sticky flag while disabled
    src = 8'h04;                    step(0, 0, 0, "R5 event while off");
    gset = 1;                       step(0, 0, 1, "R4 set enable");
    retire = 1;                     step(0, 0, 1, "R3 source disabled");
    en = 8'h04; retire = 1;         step(1, 4, 0, "R5 remembered flag taken");
    ivsel = 1;                      step(1, 4, 0, "R11 held vector");
    ivsel = 0; ack = 1;             step(0, 0, 0, "R11 ack clears");
    gset = 1; retire = 1;           step(0, 0, 1, "R3 enable not yet on");
    retire = 1;                     step(0, 0, 1, "R5 hw cleared flag");

    // R2 priority, nesting, hold
    en = 8'hFE; src = 8'hA8;        step(0, 0, 1, "R3 no retire");
    src = 8'hA0; retire = 1;        step(1, 6, 0, "R2 lowest index wins");
    gset = 1;                       step(1, 6, 1, "R4 nesting set");
    retire = 1;                     step(1, 6, 1, "R11 no decision while held");
    ack = 1;                        step(0, 0, 1, "R11 ack");
    retire = 1;                     step(1, 10, 0, "R2 level 5 over 7");
    src = 8'h00; ack = 1;           step(0, 0, 0, "R11 ack");

    // R7 level without memory
    gset = 1; en = 8'hBE; src = 8'h40; step(0, 0, 1, "R7 level while disabled");
    src = 8'h00; en = 8'hFE; retire = 1; step(0, 0, 1, "R7 condition gone");

    // R9 disable in the same cycle
    src = 8'h02; retire = 1; gclr = 1; step(0, 0, 0, "R9 same-cycle disable");
    gset = 1;                       step(0, 0, 1, "R4 set enable");
    retire = 1;                     step(1, 2, 0, "R5 flag after disable");
    ack = 1;                        step(0, 0, 0, "R11 ack");

    // R6 software clear
    en = 8'hF0; src = 8'h04;        step(0, 0, 0, "R6 event");
    clr_we = 1; clr_data = 8'h04;   step(0, 0, 0, "R6 clear write");
    gset = 1;                       step(0, 0, 1, "R4 set enable");
    en = 8'hFE; retire = 1;         step(0, 0, 1, "R6 cleared flag ignored");
    src = 8'h08; clr_we = 1; clr_data = 8'h08; step(0, 0, 1, "R6 event vs clear");
    retire = 1;                     step(1, 6, 0, "R6 event wins");
    ack = 1;                        step(0, 0, 0, "R11 ack");

    // R8 one instruction after return
    src = 8'h02;                    step(0, 0, 0, "R8 pending in handler");
    reti = 1;                       step(0, 0, 1, "R4 return sets enable");
    retire = 1;                     step(0, 0, 1, "R8 first retire blocked");
    retire = 1;                     step(1, 2, 0, "R8 second retire takes");
    ack = 1;                        step(0, 0, 0, "R11 ack");

    // R10 boot base
    gset = 1;                       step(0, 0, 1, "R4 set enable");
    ivsel = 1; src = 8'h04;         step(0, 0, 1, "R3 no retire");
    retire = 1;                     step(1, BOOT + 12'd4, 0, "R10 boot vector");
    ack = 1; ivsel = 0;             step(0, 0, 0, "R11 ack");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule